// File: doc/BRIEF.md
# Segmented Row-Column Unit-Cell Decoder

This block turns an 8-bit sample code into the switch controls of a segmented current-steering converter. The six most significant bits select how many of 63 equal unit cells are on. The two least significant bits drive two binary-weighted cells directly. The unit cells sit in an 8 by 8 grid. Bits 7:5 feed a row thermometer decoder and bits 4:2 feed a column thermometer decoder. Each cell then works out its own state from three signals: its row level, the level of the row above it, and its column level. No single wide 6-to-63 decoder is needed.

A grid of 64 positions holds one more cell than the 63 the code can address. The last position, row 7 column 7, is a dummy and is always off. The code is captured in an input register. The whole enable set is captured in an output register. All switch controls therefore change on the same clock edge, two edges after the code is presented.

Top module: `seg_dac_decoder`

## Requirements
- R1: The number of bits set in `unit_en` equals the value of `code_in[7:2]` (0 to 63).
- R2: `bin_en[1]` (weight 2 LSB) equals code bit 1 and `bin_en[0]` (weight 1 LSB) equals code bit 0.
- R3: Count each set `unit_en` bit as 4 LSB and add the two binary weights. The total equals the code value for every one of the 256 codes.
- R4: Cells fill in row-major order. `unit_en` bit k belongs to row k/8 and column k%8. Bit k is set exactly when k < `code_in[7:2]`. A code whose bits 4:2 are zero therefore lights whole rows only.
- R5: The dummy position (row 7, column 7) is never enabled, and `dummy_en` stays 0.
- R6: A code present at `code_in` at rising edge n appears on `unit_en` and `bin_en` after rising edge n+1.
- R7: While `rst_n` is low at a rising edge, every output register clears to 0 (synchronous, active low).
- R8: When the code grows from one cycle to the next, no unit cell that was on turns off.
- R9: A one-LSB step that carries into bit 2 (for example 0x03 to 0x04, or 0x1F to 0x20) adds exactly one unit cell and clears both binary enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | 8 | Sample code |
| unit_en | output | 63 | Unit-cell enables, row-major, dummy omitted |
| bin_en | output | 2 | Binary enables, bit 1 = 2 LSB, bit 0 = 1 LSB |
| dummy_en | output | 1 | Dummy cell enable, always 0 |

## Verification
On every cycle the assertions check several properties:
- the unit count against the registered code,
- the binary bits against the code two edges earlier,
- the thermometer shape of both decoders,
- that the dummy cell's local rule never turns it on,
- that cells only turn on while the count is growing.

Only the bench scenarios can show the exact row-major position of every lit cell and the summed weight over all 256 codes. They also cover the carry steps at 0x03 to 0x04 and 0x1F to 0x20, and a reset applied in the middle of traffic.

// File: rtl/seg_dac_pkg.sv
// Package: shared sizing for the segmented unit-cell decoder.
// Assumes the unary field is split into row bits (upper) and column bits (lower).
package seg_dac_pkg;
    localparam int DEF_ROW_BITS = 3;
    localparam int DEF_COL_BITS = 3;
    localparam int DEF_BIN_BITS = 2;

    // Row-major flat index of a grid position.
    function automatic int cell_index(input int row, input int col, input int cols);
        return row * cols + col;
    endfunction
endpackage

// File: rtl/thermo_level_dec.sv
// Module: thermo_level_dec
// Converts an IN_W-bit value into a 2**IN_W-wide thermometer.
// INCLUSIVE=1 sets level[k] when value >= k; INCLUSIVE=0 sets it when value > k.
// Assumes a single comparator level per output (one logic level deep).
module thermo_level_dec #(
    parameter int IN_W      = 3,
    parameter bit INCLUSIVE = 1'b1,
    localparam int LEVELS   = 2 ** IN_W
) (
    input  logic [IN_W-1:0]   value,
    output logic [LEVELS-1:0] level
);
    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        if (INCLUSIVE) begin : g_inc
            // Level k is on for any value at or above k.
            assign level[k] = (value >= IN_W'(k));
        end else begin : g_exc
            // Level k is on for any value strictly above k.
            assign level[k] = (value > IN_W'(k));
        end
    end

    for (genvar k = 1; k < LEVELS; k++) begin : g_chk
        // Thermometer shape: a set level implies every lower level is set.
        always_comb begin
            if (!$isunknown(level)) begin
                assert_thermo_shape_R4: assert (!level[k] || level[k-1])
                    else $error("thermometer gap at level %0d", k);
            end
        end
    end
endmodule

// File: rtl/unit_cell_logic.sv
// Module: unit_cell_logic
// Local enable rule for one grid cell: on when the row above is on,
// or when its own row and its column are both on.
// Assumes a row above that is on implies the cell's own row is on.
module unit_cell_logic (
    input  logic row_on,
    input  logic above_on,
    input  logic col_on,
    output logic cell_on
);
    // Two-level AND-OR enable.
    assign cell_on = above_on | (row_on & col_on);
endmodule

// File: rtl/cell_grid.sv
// Module: cell_grid
// Instantiates a ROWS x COLS array of local-rule cells. Returns the unit
// enables in row-major order with the last (dummy) position split off.
// Assumes row levels are inclusive and column levels are strict thermometers.
module cell_grid #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    localparam int CELLS   = ROWS * COLS,
    localparam int UNITS   = CELLS - 1
) (
    input  logic [ROWS-1:0]  row_lvl,
    input  logic [COLS-1:0]  col_lvl,
    output logic [UNITS-1:0] unit_on,
    output logic             dummy_raw
);
    import seg_dac_pkg::*;

    logic [CELLS-1:0] cell_on;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        logic above;
        if (i == ROWS - 1) begin : g_top
            // The highest row has no row above it.
            assign above = 1'b0;
        end else begin : g_mid
            // The row above comes from the next thermometer level.
            assign above = row_lvl[i+1];
        end
        for (genvar j = 0; j < COLS; j++) begin : g_col
            unit_cell_logic u_cell (
                .row_on   (row_lvl[i]),
                .above_on (above),
                .col_on   (col_lvl[j]),
                .cell_on  (cell_on[cell_index(i, j, COLS)])
            );
        end
    end

    // The dummy is the last row-major position; the rest form the unit bus.
    assign unit_on   = cell_on[UNITS-1:0];
    assign dummy_raw = cell_on[CELLS-1];

    // The dummy's own local rule must never select it.
    always_comb begin
        if (!$isunknown(dummy_raw)) begin
            assert_dummy_idle_R5: assert (dummy_raw == 1'b0)
                else $error("dummy cell selected by local rule");
        end
    end
endmodule

// File: rtl/seg_dac_decoder.sv
// Module: seg_dac_decoder (top)
// Registers the sample code, decodes the upper field into row and column
// thermometers, forms the unit enables through the cell grid, and registers
// all enables together. Latency is two rising edges from code_in.
// Assumes the code field order is {row bits, column bits, binary bits}.
module seg_dac_decoder #(
    parameter int ROW_BITS = seg_dac_pkg::DEF_ROW_BITS,
    parameter int COL_BITS = seg_dac_pkg::DEF_COL_BITS,
    parameter int BIN_BITS = seg_dac_pkg::DEF_BIN_BITS,
    localparam int UNARY_W = ROW_BITS + COL_BITS,
    localparam int CODE_W  = UNARY_W + BIN_BITS,
    localparam int ROWS    = 2 ** ROW_BITS,
    localparam int COLS    = 2 ** COL_BITS,
    localparam int UNITS   = ROWS * COLS - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   code_in,
    output logic [UNITS-1:0]    unit_en,
    output logic [BIN_BITS-1:0] bin_en,
    output logic                dummy_en
);
    logic [CODE_W-1:0] code_q;
    logic [ROWS-1:0]   row_lvl;
    logic [COLS-1:0]   col_lvl;
    logic [UNITS-1:0]  unit_d;
    logic              dummy_raw;
    logic              seen_q;
    logic              seen2_q;

    // Capture the incoming code.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_in;
    end

    thermo_level_dec #(.IN_W(ROW_BITS), .INCLUSIVE(1'b1)) u_row_dec (
        .value (code_q[CODE_W-1 -: ROW_BITS]),
        .level (row_lvl)
    );

    thermo_level_dec #(.IN_W(COL_BITS), .INCLUSIVE(1'b0)) u_col_dec (
        .value (code_q[BIN_BITS +: COL_BITS]),
        .level (col_lvl)
    );

    cell_grid #(.ROWS(ROWS), .COLS(COLS)) u_grid (
        .row_lvl   (row_lvl),
        .col_lvl   (col_lvl),
        .unit_on   (unit_d),
        .dummy_raw (dummy_raw)
    );

    // Register every switch control on one common edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_en  <= '0;
            bin_en   <= '0;
            dummy_en <= 1'b0;
        end else begin
            unit_en  <= unit_d;
            bin_en   <= code_q[BIN_BITS-1:0];
            dummy_en <= 1'b0;
        end
    end

    // Track how many clean edges have passed since reset, for $past checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            seen2_q <= 1'b0;
        end else begin
            seen_q  <= 1'b1;
            seen2_q <= seen_q;
        end
    end

    assert_unit_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ($countones(unit_en) == int'($past(code_q[CODE_W-1:BIN_BITS]))))
        else $error("unit count mismatch");

    assert_bin_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (bin_en == $past(code_q[BIN_BITS-1:0])))
        else $error("binary enable mismatch");

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen2_q |-> (bin_en == $past(code_in[BIN_BITS-1:0], 2)))
        else $error("latency mismatch");

    assert_no_dummy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> !dummy_en)
        else $error("dummy enabled");

    assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($countones(unit_en) >= $countones($past(unit_en))))
        |-> ((unit_en & $past(unit_en)) == $past(unit_en)))
        else $error("cell dropped on rising count");
endmodule

// File: tb/sim_seg_dac_decoder.sv
module sim_seg_dac_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int UNITS      = 63;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       code_in = '0;
    logic [UNITS-1:0] unit_en;
    logic [1:0]       bin_en;
    logic             dummy_en;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic [7:0] code;
        int         due;
    } item_t;
    item_t sb_q[$];

    logic [7:0]       prev_code;
    logic [UNITS-1:0] prev_units;
    bit               have_prev = 1'b0;

    seg_dac_decoder u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_in  (code_in),
        .unit_en  (unit_en),
        .bin_en   (bin_en),
        .dummy_en (dummy_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: present one code and record when its result is due.
    task automatic drive(input logic [7:0] c);
        item_t it;
        @(negedge clk);
        code_in = c;
        it.code = c;
        it.due  = cyc + 2;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each due item against the requirements.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                item_t it;
                logic [UNITS-1:0] exp_u;
                int cnt;
                it = sb_q.pop_front();
                for (int k = 0; k < UNITS; k++) exp_u[k] = (k < int'(it.code[7:2]));
                cnt = $countones(unit_en);
                check(unit_en == exp_u, "R4", "cell pattern", unit_en, exp_u);
                check(cnt == int'(it.code[7:2]), "R1", "unit count", cnt, it.code[7:2]);
                check(bin_en == it.code[1:0], "R2", "binary", bin_en, it.code[1:0]);
                check(4*cnt + 2*bin_en[1] + bin_en[0] == int'(it.code), "R3", "weight",
                      4*cnt + 2*bin_en[1] + bin_en[0], it.code);
                check(dummy_en == 1'b0, "R5", "dummy", dummy_en, 0);
                if (have_prev && it.code > prev_code)
                    check((unit_en & prev_units) == prev_units, "R8", "monotonic",
                          unit_en, prev_units);
                if (have_prev && it.code == prev_code + 8'd1 && it.code[1:0] == 2'b00) begin
                    check(cnt == $countones(prev_units) + 1, "R9", "carry adds one cell",
                          cnt, $countones(prev_units) + 1);
                    check(bin_en == 2'b00, "R9", "carry clears binary", bin_en, 0);
                end
                prev_code  = it.code;
                prev_units = unit_en;
                have_prev  = 1'b1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        check(unit_en == '0 && bin_en == '0 && dummy_en == 1'b0, "R7", "reset state",
              {unit_en, bin_en}, 0);
        rst_n = 1'b1;

        // R6: single isolated code, check exact edge of appearance.
        @(negedge clk);
        code_in = 8'hB6;
        @(negedge clk);
        code_in = 8'h00;
        check(bin_en == 2'b00, "R6", "not yet visible after one edge", bin_en, 0);
        @(negedge clk);
        check(bin_en == 2'b10 && $countones(unit_en) == 45, "R6", "visible after two edges",
              {bin_en, 8'($countones(unit_en))}, {2'b10, 8'd45});
        repeat (3) @(negedge clk);

        // Ascending sweep covers R9 steps 0x03->0x04 and 0x1F->0x20.
        for (int c = 0; c < 256; c++) drive(8'(c));
        for (int c = 255; c >= 0; c--) drive(8'(c));
        lfsr = 8'h5A;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr);
        end
        drive(8'h03); drive(8'h04); drive(8'h1F); drive(8'h20);
        wait (sb_q.size() == 0);

        // R7: reset in the middle of traffic clears all outputs.
        @(negedge clk);
        code_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(unit_en == '0 && bin_en == '0, "R7", "mid-run reset", {unit_en, bin_en}, 0);
        rst_n = 1'b1;
        have_prev = 1'b0;
        drive(8'h81);
        wait (sb_q.size() == 0);
        @(negedge clk);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule